// File: doc/BRIEF.md
# Cache Line Fill Buffer

When a cache misses, the line comes back from the next storage level over a bus much narrower than the line. By default that is sixteen 128-bit beats. This block accepts one outstanding miss and holds the returning line. It records, beat by beat, which parts of the line have arrived. Fetches aimed at the loading line are answered from those beats. If a fetch asks for a beat that is landing in the same cycle, that beat is forwarded straight to the requester.

The block copies the line into the cache data array one beat per cycle. It does so only on cycles in which the array owner raises a grant. Copies go in arrival order, starting at the first beat returned and wrapping around the line. After the last beat is written, the block pulses a strobe that marks the directory entry valid. The same edge frees the buffer for the next miss.

The block does not contain the data array, the directory lookup or the replacement choice.

Top module: `line_fill_buf`

## Requirements
- R1: Reset state: after synchronous active-high reset, miss_ready is 1 and rd_hit, rd_wait, wr_valid and dir_set_valid are all 0.
- R2: A miss is accepted only while the buffer is empty (miss_ready=1). From the cycle after acceptance, miss_ready is 0 until the directory strobe cycle. A miss_valid raised while busy has no effect: its line neither hits nor waits.
- R3: A fetch (rd_req=1) whose rd_line equals the loading line gets rd_hit=1 and rd_wait=0 in the same cycle if beat rd_beat is already held. rd_data then equals that beat's data.
- R4: A fetch to the loading line whose beat has not yet arrived gets rd_wait=1 and rd_hit=0 in the same cycle.
- R5: A fetch to the beat that arrives in the same cycle (ret_valid=1, ret_beat=rd_beat) gets rd_hit=1 with rd_data equal to ret_data.
- R6: A fetch to any other line, or any fetch while the buffer is empty, gets rd_hit=0 and rd_wait=0.
- R7: wr_valid is raised only for a beat already held. Install writes follow arrival order: the first beat returned goes first, then the index rises by one modulo 16. The offered beat index is wr_beat, its data is wr_data and its line is wr_line. The offer holds unchanged until wr_grant=1 in a cycle with wr_valid=1. Each beat is written exactly once.
- R8: dir_set_valid is 1 for exactly one cycle: the cycle after the grant of the 16th install write. In that cycle dir_line equals the filled line and miss_ready is 1.
- R9: Beats already written to the array stay readable from the buffer (rd_hit=1, correct data) until the buffer is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | New miss request |
| miss_line | input | 24 | Line address of the miss |
| miss_ready | output | 1 | Buffer empty, miss can be taken |
| ret_valid | input | 1 | A returning beat is present |
| ret_beat | input | 4 | Index of the returning beat in the line |
| ret_data | input | 128 | Returning beat data |
| rd_req | input | 1 | Requester fetch |
| rd_line | input | 24 | Line address of the fetch |
| rd_beat | input | 4 | Beat index of the fetch |
| rd_hit | output | 1 | Fetch satisfied by the buffer |
| rd_wait | output | 1 | Fetch targets the loading line but its beat is absent |
| rd_data | output | 128 | Data for a hitting fetch |
| wr_valid | output | 1 | Install write offered to the array |
| wr_grant | input | 1 | Array free this cycle, offered write taken |
| wr_beat | output | 4 | Beat index of the install write |
| wr_line | output | 24 | Line address of the install write |
| wr_data | output | 128 | Data of the install write |
| dir_set_valid | output | 1 | One-cycle strobe: line fully installed |
| dir_line | output | 24 | Line address for the directory strobe |

## Verification
The embedded properties rely on the next level behaving correctly. Beats are presented only while a miss is outstanding. Each index of the line appears once, starting at some critical beat and wrapping upward. The grant input is treated as arbitrary. The bench drives only such return sequences: one line with a mid-line critical beat whose returns wrap past index 15, and one starting at beat 0. It holds grants off, toggles them and holds them on, so the ordering and hold rules are exercised under all three array-availability patterns.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
    localparam int unsigned LFB_BEATS  = 16;
    localparam int unsigned LFB_DATA_W = 128;
    localparam int unsigned LFB_LINE_W = 24;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_e;

    // next beat index in wrap order
    function automatic int unsigned wrap_next(input int unsigned b, input int unsigned n);
        return (b + 1) % n;
    endfunction
endpackage

// File: rtl/lfb_beat_store.sv
module lfb_beat_store #(
    parameter int unsigned BEATS = lfb_pkg::LFB_BEATS,
    parameter int unsigned DW    = lfb_pkg::LFB_DATA_W,
    localparam int unsigned BW   = $clog2(BEATS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       busy,
    input  logic                       clear,
    input  logic                       ret_valid,
    input  logic [BW-1:0]              ret_beat,
    input  logic [DW-1:0]              ret_data,
    output logic [BEATS-1:0]           valid_mask,
    output logic [BEATS-1:0][DW-1:0]   beat_data,
    output logic                       first_beat
);
    logic take;
    assign take       = busy && ret_valid;
    assign first_beat = take && (valid_mask == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            valid_mask <= '0;
        end else if (take) begin
            valid_mask[ret_beat] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            beat_data[ret_beat] <= ret_data;
        end
    end

    // R3 arrived beats stay present until the buffer is freed
    valid_grow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(clear) |-> ((valid_mask & $past(valid_mask)) == $past(valid_mask)));
endmodule

// File: rtl/lfb_install_ctl.sv
module lfb_install_ctl #(
    parameter int unsigned BEATS = lfb_pkg::LFB_BEATS,
    parameter int unsigned DW    = lfb_pkg::LFB_DATA_W,
    localparam int unsigned BW   = $clog2(BEATS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       busy,
    input  logic                       first_beat,
    input  logic [BW-1:0]              first_idx,
    input  logic [BEATS-1:0]           valid_mask,
    input  logic [BEATS-1:0][DW-1:0]   beat_data,
    input  logic                       wr_grant,
    output logic                       wr_valid,
    output logic [BW-1:0]              wr_beat,
    output logic [DW-1:0]              wr_data,
    output logic                       last_install
);
    import lfb_pkg::*;

    logic [BW-1:0]    ptr;
    logic [BEATS-1:0] inst_mask;
    logic [BEATS-1:0] ptr_bit;
    logic             take;

    assign ptr_bit      = BEATS'(1) << ptr;
    assign wr_valid     = busy && valid_mask[ptr] && !inst_mask[ptr];
    assign wr_beat      = ptr;
    assign wr_data      = beat_data[ptr];
    assign take         = wr_valid && wr_grant;
    assign last_install = take && ((inst_mask | ptr_bit) == '1);

    always_ff @(posedge clk) begin
        if (rst || last_install) begin
            ptr       <= '0;
            inst_mask <= '0;
        end else if (first_beat) begin
            ptr <= first_idx;
        end else if (take) begin
            inst_mask[ptr] <= 1'b1;
            ptr            <= BW'(wrap_next(32'(ptr), BEATS));
        end
    end

    // R7 only a beat that has arrived is offered to the array
    wr_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> valid_mask[wr_beat]);

    // R7 an offer that is not granted is held unchanged
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_grant) |=> (wr_valid && $stable(wr_beat) && $stable(wr_data)));

    // R7 a granted beat is followed by the next index in wrap order
    wr_order_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !last_install && wr_beat != BW'(BEATS - 1)) |=> (wr_beat == $past(wr_beat) + 1'b1));
endmodule

// File: rtl/lfb_fetch_mux.sv
module lfb_fetch_mux #(
    parameter int unsigned BEATS = lfb_pkg::LFB_BEATS,
    parameter int unsigned DW    = lfb_pkg::LFB_DATA_W,
    parameter int unsigned LW    = lfb_pkg::LFB_LINE_W,
    localparam int unsigned BW   = $clog2(BEATS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       busy,
    input  logic [LW-1:0]              line_q,
    input  logic [BEATS-1:0]           valid_mask,
    input  logic [BEATS-1:0][DW-1:0]   beat_data,
    input  logic                       ret_valid,
    input  logic [BW-1:0]              ret_beat,
    input  logic [DW-1:0]              ret_data,
    input  logic                       rd_req,
    input  logic [LW-1:0]              rd_line,
    input  logic [BW-1:0]              rd_beat,
    output logic                       rd_hit,
    output logic                       rd_wait,
    output logic [DW-1:0]              rd_data
);
    logic match, held, bypass;

    assign match  = busy && rd_req && (rd_line == line_q);
    assign held   = valid_mask[rd_beat];
    assign bypass = ret_valid && (ret_beat == rd_beat);

    always_comb begin
        rd_hit  = match && (held || bypass);
        rd_wait = match && !(held || bypass);
        if (!rd_hit)     rd_data = '0;
        else if (held)   rd_data = beat_data[rd_beat];
        else             rd_data = ret_data;
    end

    // R4 hit and wait are never given together
    hit_wait_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_hit && rd_wait));

    // R6 an empty buffer answers nothing
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rd_hit && !rd_wait));
endmodule

// File: rtl/line_fill_buf.sv
module line_fill_buf #(
    parameter int unsigned BEATS = lfb_pkg::LFB_BEATS,
    parameter int unsigned DW    = lfb_pkg::LFB_DATA_W,
    parameter int unsigned LW    = lfb_pkg::LFB_LINE_W,
    localparam int unsigned BW   = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          miss_valid,
    input  logic [LW-1:0] miss_line,
    output logic          miss_ready,
    input  logic          ret_valid,
    input  logic [BW-1:0] ret_beat,
    input  logic [DW-1:0] ret_data,
    input  logic          rd_req,
    input  logic [LW-1:0] rd_line,
    input  logic [BW-1:0] rd_beat,
    output logic          rd_hit,
    output logic          rd_wait,
    output logic [DW-1:0] rd_data,
    output logic          wr_valid,
    input  logic          wr_grant,
    output logic [BW-1:0] wr_beat,
    output logic [LW-1:0] wr_line,
    output logic [DW-1:0] wr_data,
    output logic          dir_set_valid,
    output logic [LW-1:0] dir_line
);
    import lfb_pkg::*;

    fill_state_e              state;
    logic [LW-1:0]            line_q;
    logic                     dir_q;
    logic                     busy, accept, last_install, first_beat;
    logic [BEATS-1:0]         valid_mask;
    logic [BEATS-1:0][DW-1:0] beat_data;

    assign busy          = (state == FILL_BUSY);
    assign miss_ready    = !busy;
    assign accept        = miss_valid && miss_ready;
    assign wr_line       = line_q;
    assign dir_line      = line_q;
    assign dir_set_valid = dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FILL_IDLE;
            line_q <= '0;
            dir_q  <= 1'b0;
        end else begin
            dir_q <= last_install;
            if (accept) begin
                state  <= FILL_BUSY;
                line_q <= miss_line;
            end else if (last_install) begin
                state <= FILL_IDLE;
            end
        end
    end

    lfb_beat_store #(.BEATS(BEATS), .DW(DW)) u_store (
        .clk(clk), .rst(rst), .busy(busy), .clear(last_install),
        .ret_valid(ret_valid), .ret_beat(ret_beat), .ret_data(ret_data),
        .valid_mask(valid_mask), .beat_data(beat_data), .first_beat(first_beat)
    );

    lfb_install_ctl #(.BEATS(BEATS), .DW(DW)) u_inst (
        .clk(clk), .rst(rst), .busy(busy), .first_beat(first_beat),
        .first_idx(ret_beat), .valid_mask(valid_mask), .beat_data(beat_data),
        .wr_grant(wr_grant), .wr_valid(wr_valid), .wr_beat(wr_beat),
        .wr_data(wr_data), .last_install(last_install)
    );

    lfb_fetch_mux #(.BEATS(BEATS), .DW(DW), .LW(LW)) u_fetch (
        .clk(clk), .rst(rst), .busy(busy), .line_q(line_q),
        .valid_mask(valid_mask), .beat_data(beat_data),
        .ret_valid(ret_valid), .ret_beat(ret_beat), .ret_data(ret_data),
        .rd_req(rd_req), .rd_line(rd_line), .rd_beat(rd_beat),
        .rd_hit(rd_hit), .rd_wait(rd_wait), .rd_data(rd_data)
    );

    // R2 an accepted miss closes the buffer to further misses
    accept_close_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=> !miss_ready);

    // R8 the directory strobe lasts a single cycle
    dir_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dir_set_valid |=> !dir_set_valid);

    // R8 the buffer is free when the strobe is seen
    dir_free_chk: assert property (@(posedge clk) disable iff (rst)
        dir_set_valid |-> (miss_ready && !wr_valid));
endmodule

// File: tb/line_fill_buf_test.sv
module line_fill_buf_test;
    logic          clk = 1'b0;
    logic          rst;
    logic          miss_valid;
    logic [23:0]   miss_line;
    logic          miss_ready;
    logic          ret_valid;
    logic [3:0]    ret_beat;
    logic [127:0]  ret_data;
    logic          rd_req;
    logic [23:0]   rd_line;
    logic [3:0]    rd_beat;
    logic          rd_hit, rd_wait;
    logic [127:0]  rd_data;
    logic          wr_valid, wr_grant;
    logic [3:0]    wr_beat;
    logic [23:0]   wr_line;
    logic [127:0]  wr_data;
    logic          dir_set_valid;
    logic [23:0]   dir_line;

    int checks = 0;
    int errors = 0;
    int exp_beat[$];
    logic [127:0] exp_data[$];
    logic [23:0]  cur_line;

    always #2 clk = ~clk;

    line_fill_buf uut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_line(miss_line),
        .miss_ready(miss_ready), .ret_valid(ret_valid), .ret_beat(ret_beat),
        .ret_data(ret_data), .rd_req(rd_req), .rd_line(rd_line), .rd_beat(rd_beat),
        .rd_hit(rd_hit), .rd_wait(rd_wait), .rd_data(rd_data), .wr_valid(wr_valid),
        .wr_grant(wr_grant), .wr_beat(wr_beat), .wr_line(wr_line), .wr_data(wr_data),
        .dir_set_valid(dir_set_valid), .dir_line(dir_line)
    );

    function automatic logic [127:0] pat(input logic [23:0] l, input int b);
        return {4{l[7:0], 4'(b), 20'h5A5A5}};
    endfunction

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: compare every granted install write with the scoreboard (R7)
    always @(negedge clk) begin
        #1;
        if (!rst && wr_valid && wr_grant) begin
            if (exp_beat.size() == 0) begin
                chk("R7", "unexpected install", 128'(wr_beat), 128'hFFFF);
            end else begin
                chk("R7", "install beat", 128'(wr_beat), 128'(exp_beat.pop_front()));
                chk("R7", "install data", wr_data, exp_data.pop_front());
                chk("R7", "install line", 128'(wr_line), 128'(cur_line));
            end
        end
    end

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        finish_run();
    end

    task automatic fetch(input logic [23:0] l, input int b);
        rd_req = 1'b1; rd_line = l; rd_beat = 4'(b);
    endtask

    task automatic ret(input logic [23:0] l, input int b);
        ret_valid = 1'b1; ret_beat = 4'(b); ret_data = pat(l, b);
        exp_beat.push_back(b); exp_data.push_back(pat(l, b));
    endtask

    task automatic start_miss(input logic [23:0] l);
        @(negedge clk);
        miss_valid = 1'b1; miss_line = l; cur_line = l;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic wait_dir(input logic [23:0] l, input bit toggle);
        bit seen = 0;
        for (int i = 0; i < 100 && !seen; i++) begin
            @(negedge clk);
            ret_valid = 1'b0; rd_req = 1'b0;
            wr_grant = toggle ? i[0] : 1'b1;
            if (i < 6) fetch(l, 6);
            #1;
            if (i < 6 && !dir_set_valid) begin
                chk("R9", "installed beat hit", 128'(rd_hit), 128'd1);
                chk("R9", "installed beat data", rd_data, pat(l, 6));
            end
            if (dir_set_valid) begin
                seen = 1;
                chk("R8", "dir line", 128'(dir_line), 128'(l));
                chk("R8", "ready at strobe", 128'(miss_ready), 128'd1);
                chk("R7", "all installs done", 128'(exp_beat.size()), 128'd0);
            end
        end
        chk("R8", "strobe seen", 128'(seen), 128'd1);
        @(negedge clk);
        wr_grant = 1'b0; fetch(l, 3);
        #1;
        chk("R8", "strobe one cycle", 128'(dir_set_valid), 128'd0);
        chk("R6", "freed line hit", 128'(rd_hit), 128'd0);
        chk("R6", "freed line wait", 128'(rd_wait), 128'd0);
    endtask

    localparam logic [23:0] LA = 24'h0A11C3;
    localparam logic [23:0] LB = 24'h07D042;
    localparam logic [23:0] LC = 24'h00BEEF;

    initial begin
        rst = 1'b1; miss_valid = 0; miss_line = '0; ret_valid = 0; ret_beat = '0;
        ret_data = '0; rd_req = 0; rd_line = '0; rd_beat = '0; wr_grant = 0; cur_line = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        fetch(LA, 0);
        #1;
        chk("R1", "miss_ready", 128'(miss_ready), 128'd1);
        chk("R1", "wr_valid", 128'(wr_valid), 128'd0);
        chk("R1", "dir_set_valid", 128'(dir_set_valid), 128'd0);
        chk("R1", "rd_hit", 128'(rd_hit), 128'd0);
        chk("R1", "rd_wait", 128'(rd_wait), 128'd0);
        rd_req = 1'b0;

        // line A, critical beat 5, grants held off while loading
        start_miss(LA);
        fetch(LA, 7);
        #1;
        chk("R2", "busy after accept", 128'(miss_ready), 128'd0);
        chk("R4", "absent beat wait", 128'(rd_wait), 128'd1);
        chk("R4", "absent beat no hit", 128'(rd_hit), 128'd0);
        chk("R7", "no offer before data", 128'(wr_valid), 128'd0);
        @(negedge clk);
        rd_req = 1'b0; miss_valid = 1'b1; miss_line = LB;
        @(negedge clk);
        miss_valid = 1'b0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            ret(LA, (5 + k) % 16);
            fetch(LA, (5 + k) % 16);
            #1;
            chk("R5", "bypass hit", 128'(rd_hit), 128'd1);
            chk("R5", "bypass data", rd_data, pat(LA, (5 + k) % 16));
            if (k == 3) begin
                chk("R7", "offer held", 128'(wr_valid), 128'd1);
                chk("R7", "offer is critical beat", 128'(wr_beat), 128'd5);
            end
        end
        @(negedge clk);
        ret_valid = 1'b0; fetch(LB, 5);
        #1;
        chk("R2", "ignored miss hit", 128'(rd_hit), 128'd0);
        chk("R6", "other line wait", 128'(rd_wait), 128'd0);
        foreach (exp_beat[i]) if (i < 3) begin
            @(negedge clk);
            fetch(LA, (i == 0) ? 4 : (i == 1) ? 0 : 15);
            #1;
            chk("R3", "held beat hit", 128'(rd_hit), 128'd1);
            chk("R3", "held beat data", rd_data, pat(LA, (i == 0) ? 4 : (i == 1) ? 0 : 15));
        end
        wait_dir(LA, 1'b1);

        // line C, critical beat 0, array always free
        start_miss(LC);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            wr_grant = 1'b1; ret(LC, k);
            if (k == 8) fetch(LC, 2); else rd_req = 1'b0;
            #1;
            if (k == 8) begin
                chk("R9", "early installed beat", 128'(rd_hit), 128'd1);
                chk("R9", "early installed data", rd_data, pat(LC, 2));
            end
        end
        wait_dir(LC, 1'b0);
        finish_run();
    end
endmodule